// File: doc/BRIEF.md
# Two-Pattern Gapped Frame Sync Detector

This block finds the start of a frame on a serial Manchester chip stream when the start marker is two sync patterns sent in order with a fixed number of chips between them. A first correlator watches the stream for pattern A. Once A is found, a programmed number of gap chips is counted without being compared. A second correlator then looks for pattern B inside a tolerance window. Only when B completes does the block pulse frame sync and start decoding payload chip pairs into bits. If B does not show up before the window closes, a one-cycle timeout is raised and the search for A starts again.

A configuration bit selects between this two-pattern mode and a plain single-pattern mode, in which a match on A alone starts the payload. Chips arrive with a chip-enable qualifier, and only enabled cycles advance the logic. The controller is a four-state machine. In SEARCH_A it correlates against A. On an A match it goes to GAP, or to WINDOW_B when the gap is zero, or to PAYLOAD in single mode. GAP moves to WINDOW_B on the last gap chip. WINDOW_B goes to PAYLOAD on a B match, or back to SEARCH_A on timeout. PAYLOAD returns to SEARCH_A once the programmed bit count has been delivered.

Top module: `gap_sync_detector`

## Requirements
- R1: After reset the state is SEARCH_A, and sync_o, timeout_o, bit_valid_o and bit_o are all low.
- R2: A pattern of length L (1..16) matches when the last L enabled chips equal the low L bits of its pattern input. The earliest of those chips is compared with bit L-1 and the newest with bit 0. Only chips received since the current state was entered take part.
- R3: Pattern B is never compared while the block is in SEARCH_A, so B alone produces no output event.
- R4: In GAP, exactly cfg_gap_i enabled chips are counted and none of them is compared, so a copy of B inside the gap is ignored.
- R5: In WINDOW_B, B is accepted if it completes on any of the first cfg_len_b_i + cfg_win_i enabled chips after the gap.
- R6: If B has not matched by window chip number cfg_len_b_i + cfg_win_i, timeout_o pulses for one cycle and the block returns to SEARCH_A.
- R7: In gap mode, sync_o is a one-cycle pulse in the cycle after the clock edge that takes in the last chip of B. A match on A alone gives no sync.
- R8: With cfg_gap_mode_i low, a match on A gives sync_o in the cycle after its last chip, and the payload follows with no gap or B phase.
- R9: In PAYLOAD, each pair of enabled chips yields one bit_valid_o pulse, one cycle after the pair's second chip. Pair "1 then 0" decodes to 1 and "0 then 1" decodes to 0, i.e. the bit equals the first chip of the pair.
- R10: After max(cfg_pay_bits_i, 1) bits the block returns to SEARCH_A, and a pattern A that starts on the very next chip is detected.
- R11: If B completes on the final chip of the window, sync_o pulses and timeout_o stays low.
- R12: Cycles with chip_en_i low change nothing, whatever chip_i carries.
- R13: With cfg_gap_i zero, the B window opens on the chip right after the last chip of A.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| chip_i | input | 1 | Serial chip value |
| chip_en_i | input | 1 | Chip qualifier; chip_i is taken only when high |
| cfg_gap_mode_i | input | 1 | 1: two patterns with gap; 0: single pattern A |
| cfg_pat_a_i | input | PAT_MAX | Pattern A, earliest chip in bit len-1 |
| cfg_len_a_i | input | LEN_W | Length of pattern A in chips |
| cfg_pat_b_i | input | PAT_MAX | Pattern B, earliest chip in bit len-1 |
| cfg_len_b_i | input | LEN_W | Length of pattern B in chips |
| cfg_gap_i | input | GAP_W | Gap length in chips |
| cfg_win_i | input | WIN_W | Extra window chips allowed for B |
| cfg_pay_bits_i | input | PAY_W | Payload length in decoded bits |
| sync_o | output | 1 | One-cycle frame sync pulse |
| bit_valid_o | output | 1 | One-cycle decoded-bit strobe |
| bit_o | output | 1 | Decoded payload bit, valid with bit_valid_o |
| timeout_o | output | 1 | One-cycle pulse when the B window expires |

## Verification
Two events can fall on the same window chip: B completing and the window running out. The bench provokes this by placing cfg_win_i filler chips after the gap and then sending B, so that B's last chip is exactly chip cfg_len_b_i + cfg_win_i of the window. The scoreboard then expects a single sync item and no timeout item, and any timeout pulse shows up as an unexpected or mismatched event. The other edge is the last payload bit followed directly by a new pattern A, which confirms that the payload chips leave nothing behind for the correlator.

// File: rtl/gsd_pkg.sv
package gsd_pkg;
    typedef enum logic [1:0] {
        ST_SEARCH_A = 2'd0,
        ST_GAP      = 2'd1,
        ST_WINDOW_B = 2'd2,
        ST_PAYLOAD  = 2'd3
    } gsd_state_e;
endpackage

// File: rtl/gsd_history.sv
// Chip history shift register with a saturating fill count.
// The outputs show the values as they will be after the current chip is taken in.
module gsd_history #(
    parameter int DEPTH = 16,
    parameter int CW    = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             shift_i,
    input  logic             clear_i,
    input  logic             chip_i,
    output logic [DEPTH-1:0] hist_nxt_o,
    output logic [CW-1:0]    fill_nxt_o
);
    logic [DEPTH-1:0] hist_q;
    logic [CW-1:0]    fill_q;

    always_comb begin
        hist_nxt_o = hist_q;
        fill_nxt_o = fill_q;
        if (shift_i) begin
            hist_nxt_o = {hist_q[DEPTH-2:0], chip_i};
            if (fill_q != CW'(DEPTH))
                fill_nxt_o = fill_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hist_q <= '0;
            fill_q <= '0;
        end else begin
            hist_q <= hist_nxt_o;
            fill_q <= clear_i ? '0 : fill_nxt_o;
        end
    end

    // R2: the fill count never exceeds the history depth
    p_fill_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
        fill_q <= CW'(DEPTH));
endmodule

// File: rtl/gsd_correlator.sv
// Compares the newest len_i chips of the history against a pattern.
module gsd_correlator #(
    parameter int DEPTH = 16,
    parameter int CW    = $clog2(DEPTH + 1)
) (
    input  logic [DEPTH-1:0] hist_i,
    input  logic [CW-1:0]    fill_i,
    input  logic [DEPTH-1:0] pat_i,
    input  logic [CW-1:0]    len_i,
    output logic             match_o
);
    logic [DEPTH-1:0] mask;

    for (genvar g = 0; g < DEPTH; g++) begin : g_mask
        assign mask[g] = (CW'(g) < len_i);
    end

    assign match_o = (len_i != '0) && (fill_i >= len_i) &&
                     (((hist_i ^ pat_i) & mask) == '0);
endmodule

// File: rtl/gsd_manchester.sv
// Pairs payload chips and presents the decoded bit on the second chip of each pair.
module gsd_manchester (
    input  logic clk,
    input  logic rst_n,
    input  logic clear_i,
    input  logic en_i,
    input  logic chip_i,
    output logic pair_done_o,
    output logic bit_o
);
    logic half_q;
    logic first_q;

    assign pair_done_o = en_i && half_q;
    assign bit_o       = first_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            half_q  <= 1'b0;
            first_q <= 1'b0;
        end else if (clear_i) begin
            half_q  <= 1'b0;
        end else if (en_i) begin
            half_q <= !half_q;
            if (!half_q)
                first_q <= chip_i;
        end
    end
endmodule

// File: rtl/gap_sync_detector.sv
module gap_sync_detector
    import gsd_pkg::*;
#(
    parameter int PAT_MAX = 16,
    parameter int GAP_W   = 8,
    parameter int WIN_W   = 8,
    parameter int PAY_W   = 8,
    localparam int LEN_W  = $clog2(PAT_MAX + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               chip_i,
    input  logic               chip_en_i,
    input  logic               cfg_gap_mode_i,
    input  logic [PAT_MAX-1:0] cfg_pat_a_i,
    input  logic [LEN_W-1:0]   cfg_len_a_i,
    input  logic [PAT_MAX-1:0] cfg_pat_b_i,
    input  logic [LEN_W-1:0]   cfg_len_b_i,
    input  logic [GAP_W-1:0]   cfg_gap_i,
    input  logic [WIN_W-1:0]   cfg_win_i,
    input  logic [PAY_W-1:0]   cfg_pay_bits_i,
    output logic               sync_o,
    output logic               bit_valid_o,
    output logic               bit_o,
    output logic               timeout_o
);
    localparam int WL_W  = ((WIN_W > LEN_W) ? WIN_W : LEN_W) + 1;
    localparam int GP_W  = (GAP_W > PAY_W) ? GAP_W : PAY_W;
    localparam int CNT_W = ((WL_W > GP_W) ? WL_W : GP_W) + 1;

    gsd_state_e state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d, cnt_inc, win_limit;
    logic [PAT_MAX-1:0] hist_nxt;
    logic [LEN_W-1:0]   fill_nxt;
    logic match_a, match_b, hist_clear;
    logic man_en, man_clear, pair_done, man_bit;
    logic ev_sync, ev_timeout, ev_bit;

    // ---------------- datapath ----------------
    gsd_history #(.DEPTH(PAT_MAX), .CW(LEN_W)) u_hist (
        .clk       (clk),
        .rst_n     (rst_n),
        .shift_i   (chip_en_i),
        .clear_i   (hist_clear),
        .chip_i    (chip_i),
        .hist_nxt_o(hist_nxt),
        .fill_nxt_o(fill_nxt)
    );

    gsd_correlator #(.DEPTH(PAT_MAX), .CW(LEN_W)) u_corr_a (
        .hist_i (hist_nxt),
        .fill_i (fill_nxt),
        .pat_i  (cfg_pat_a_i),
        .len_i  (cfg_len_a_i),
        .match_o(match_a)
    );

    gsd_correlator #(.DEPTH(PAT_MAX), .CW(LEN_W)) u_corr_b (
        .hist_i (hist_nxt),
        .fill_i (fill_nxt),
        .pat_i  (cfg_pat_b_i),
        .len_i  (cfg_len_b_i),
        .match_o(match_b)
    );

    assign man_en    = chip_en_i && (state_q == ST_PAYLOAD);
    assign man_clear = (state_q != ST_PAYLOAD);

    gsd_manchester u_man (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear_i    (man_clear),
        .en_i       (man_en),
        .chip_i     (chip_i),
        .pair_done_o(pair_done),
        .bit_o      (man_bit)
    );

    assign cnt_inc    = cnt_q + 1'b1;
    assign win_limit  = CNT_W'(cfg_len_b_i) + CNT_W'(cfg_win_i);
    assign hist_clear = (state_d != state_q);

    // ---------------- next state ----------------
    always_comb begin
        state_d    = state_q;
        cnt_d      = cnt_q;
        ev_sync    = 1'b0;
        ev_timeout = 1'b0;
        ev_bit     = 1'b0;
        unique case (state_q)
            ST_SEARCH_A: begin
                if (chip_en_i && match_a) begin
                    cnt_d = '0;
                    if (!cfg_gap_mode_i) begin
                        state_d = ST_PAYLOAD;
                        ev_sync = 1'b1;
                    end else if (cfg_gap_i == '0) begin
                        state_d = ST_WINDOW_B;
                    end else begin
                        state_d = ST_GAP;
                    end
                end
            end
            ST_GAP: begin
                if (chip_en_i) begin
                    if (cnt_inc >= CNT_W'(cfg_gap_i)) begin
                        state_d = ST_WINDOW_B;
                        cnt_d   = '0;
                    end else begin
                        cnt_d = cnt_inc;
                    end
                end
            end
            ST_WINDOW_B: begin
                if (chip_en_i) begin
                    if (match_b) begin
                        state_d = ST_PAYLOAD;
                        ev_sync = 1'b1;
                        cnt_d   = '0;
                    end else if (cnt_inc >= win_limit) begin
                        state_d    = ST_SEARCH_A;
                        ev_timeout = 1'b1;
                        cnt_d      = '0;
                    end else begin
                        cnt_d = cnt_inc;
                    end
                end
            end
            ST_PAYLOAD: begin
                if (pair_done) begin
                    ev_bit = 1'b1;
                    if (cnt_inc >= CNT_W'(cfg_pay_bits_i)) begin
                        state_d = ST_SEARCH_A;
                        cnt_d   = '0;
                    end else begin
                        cnt_d = cnt_inc;
                    end
                end
            end
            default: begin
                state_d = ST_SEARCH_A;
                cnt_d   = '0;
            end
        endcase
    end

    // ---------------- state register ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_SEARCH_A;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // ---------------- outputs ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_o      <= 1'b0;
            timeout_o   <= 1'b0;
            bit_valid_o <= 1'b0;
            bit_o       <= 1'b0;
        end else begin
            sync_o      <= ev_sync;
            timeout_o   <= ev_timeout;
            bit_valid_o <= ev_bit;
            bit_o       <= ev_bit ? man_bit : 1'b0;
        end
    end

    // ---------------- assertions ----------------
    // R7: a sync pulse always coincides with the payload state
    p_sync_in_payload_r7: assert property (@(posedge clk) disable iff (!rst_n)
        sync_o |-> (state_q == ST_PAYLOAD));
    // R6: a timeout pulse always leaves the block searching for A
    p_timeout_to_search_r6: assert property (@(posedge clk) disable iff (!rst_n)
        timeout_o |-> (state_q == ST_SEARCH_A));
    // R11: sync and timeout never pulse together
    p_sync_excl_timeout_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !(sync_o && timeout_o));
    // R11: a B match in the window yields sync and no timeout
    p_b_match_wins_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WINDOW_B && chip_en_i && match_b) |=> (sync_o && !timeout_o));
    // R4: no sync can come out of the gap phase
    p_gap_no_sync_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_GAP) |=> !sync_o);
    // R9: decoded bits only come from the payload phase
    p_bit_from_payload_r9: assert property (@(posedge clk) disable iff (!rst_n)
        bit_valid_o |-> ($past(state_q) == ST_PAYLOAD));
    // R8: single-pattern mode never enters the gap
    p_single_no_gap_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SEARCH_A && !cfg_gap_mode_i) |=> (state_q != ST_GAP));
    // R12: a cycle without chip enable holds state and counter
    p_idle_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !chip_en_i |=> ($stable(state_q) && $stable(cnt_q)));
endmodule

// File: tb/tb_gap_sync_detector.sv
`timescale 1ns/1ps
module tb_gap_sync_detector;
    localparam int PAT_MAX = 16;
    localparam int LEN_W   = $clog2(PAT_MAX + 1);
    localparam logic [3:0] E_SYNC = 4'b1000;
    localparam logic [3:0] E_TO   = 4'b0100;
    localparam logic [3:0] E_B0   = 4'b0010;
    localparam logic [3:0] E_B1   = 4'b0011;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic chip = 1'b0, chip_en = 1'b0, gap_mode = 1'b1;
    logic [15:0] pat_a = 16'h00B4, pat_b = 16'h09A5;
    logic [LEN_W-1:0] len_a = 5'd8, len_b = 5'd12;
    logic [7:0] gap = 8'd5, win = 8'd3, pay = 8'd4;
    logic sync_o, bit_valid_o, bit_o, timeout_o;

    int checks = 0, errors = 0;
    bit done = 1'b0;
    logic [3:0] expq[$];
    string tagq[$];

    always #4 clk = ~clk;

    gap_sync_detector dut (
        .clk(clk), .rst_n(rst_n), .chip_i(chip), .chip_en_i(chip_en),
        .cfg_gap_mode_i(gap_mode), .cfg_pat_a_i(pat_a), .cfg_len_a_i(len_a),
        .cfg_pat_b_i(pat_b), .cfg_len_b_i(len_b), .cfg_gap_i(gap),
        .cfg_win_i(win), .cfg_pay_bits_i(pay),
        .sync_o(sync_o), .bit_valid_o(bit_valid_o), .bit_o(bit_o), .timeout_o(timeout_o)
    );

    // monitor: pops one expected item per output event
    always @(negedge clk) begin
        if (rst_n && (sync_o || timeout_o || bit_valid_o)) begin
            logic [3:0] got;
            got = {sync_o, timeout_o, bit_valid_o, bit_o};
            checks++;
            if (expq.size() == 0) begin
                errors++;
                $display("FAIL unexpected event: actual %b expected none", got);
            end else begin
                logic [3:0] e;
                string t;
                e = expq.pop_front();
                t = tagq.pop_front();
                if (got !== e) begin
                    errors++;
                    $display("FAIL %s: actual %b expected %b", t, got, e);
                end
            end
        end
    end

    task automatic expect_ev(input logic [3:0] e, input string t);
        expq.push_back(e);
        tagq.push_back(t);
    endtask

    // one enabled chip, then an idle cycle carrying the opposite value (R12)
    task automatic send_chip(input logic c);
        @(negedge clk);
        chip = c; chip_en = 1'b1;
        @(negedge clk);
        chip_en = 1'b0; chip = ~c;
    endtask

    task automatic send_vec(input logic [15:0] v, input int n);
        for (int i = n - 1; i >= 0; i--) send_chip(v[i]);
    endtask

    task automatic send_zeros(input int n);
        for (int i = 0; i < n; i++) send_chip(1'b0);
    endtask

    task automatic send_bit(input logic b, input string t);
        expect_ev(b ? E_B1 : E_B0, t);
        send_chip(b);
        send_chip(~b);
    endtask

    task automatic drain(input string t);
        repeat (3) @(negedge clk);
        checks++;
        if (expq.size() != 0) begin
            errors++;
            $display("FAIL %s: actual %0d events missing expected 0", t, expq.size());
            expq.delete();
            tagq.delete();
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        checks++;
        if ({sync_o, timeout_o, bit_valid_o, bit_o} !== 4'b0) begin
            errors++;
            $display("FAIL R1: actual %b expected 0000", {sync_o, timeout_o, bit_valid_o, bit_o});
        end
        rst_n = 1'b1;
        @(negedge clk);

        // R3: B in SEARCH_A is ignored
        send_vec(pat_b, 12); send_zeros(4);
        drain("R3");

        // R2 R4 R5 R7 R9: A, gap holding random chips, B at once, payload 1001
        send_zeros(3); send_vec(pat_a, 8);
        send_vec(16'h0013, 5);
        expect_ev(E_SYNC, "R7");
        send_vec(pat_b, 12);
        send_bit(1'b1, "R9"); send_bit(1'b0, "R9");
        send_bit(1'b0, "R9"); send_bit(1'b1, "R9");
        drain("R5");

        // R10 R11: back-to-back frame, B ends on the last window chip
        send_vec(pat_a, 8); send_zeros(5); send_zeros(3);
        expect_ev(E_SYNC, "R11");
        send_vec(pat_b, 12);
        send_bit(1'b0, "R10"); send_bit(1'b1, "R10");
        send_bit(1'b1, "R10"); send_bit(1'b0, "R10");
        drain("R10");

        // R6: window expires, then a full frame works again
        send_vec(pat_a, 8); send_zeros(5);
        expect_ev(E_TO, "R6");
        send_zeros(15);
        drain("R6");
        send_vec(pat_a, 8); send_zeros(5);
        expect_ev(E_SYNC, "R6");
        send_vec(pat_b, 12);
        send_bit(1'b1, "R6"); send_bit(1'b1, "R6");
        send_bit(1'b0, "R6"); send_bit(1'b0, "R6");
        drain("R6");

        // R4: a full copy of B inside a 14-chip gap is not compared
        gap = 8'd14;
        send_vec(pat_a, 8); send_vec(16'h0003, 2); send_vec(pat_b, 12);
        expect_ev(E_TO, "R4");
        send_zeros(15);
        drain("R4");

        // R13: zero gap, B follows A directly
        gap = 8'd0; pay = 8'd2;
        send_vec(pat_a, 8);
        expect_ev(E_SYNC, "R13");
        send_vec(pat_b, 12);
        send_bit(1'b1, "R13"); send_bit(1'b1, "R13");
        drain("R13");

        // R8: single-pattern mode
        gap_mode = 1'b0; pay = 8'd3;
        send_vec(pat_b, 12); send_zeros(2);
        expect_ev(E_SYNC, "R8");
        send_vec(pat_a, 8);
        send_bit(1'b0, "R8"); send_bit(1'b1, "R8"); send_bit(1'b0, "R8");
        drain("R8");

        // R2: 16-chip pattern, one-chip mismatch rejected; payload 0 acts as 1
        len_a = 5'd16; pat_a = 16'hF0C3; pay = 8'd0;
        send_vec(16'h70C3, 16); send_zeros(16);
        drain("R2");
        expect_ev(E_SYNC, "R2");
        send_vec(16'hF0C3, 16);
        send_bit(1'b1, "R10");
        send_zeros(2);
        drain("R2");

        finish_run();
    end
endmodule